// File: doc/BRIEF.md
# Fractional UART Clock Generator

This block turns a fixed reference clock into the timing strobes a UART core needs. A phase accumulator makes a clock-enable at the fractional rate Fref × MUL / DIV. A prescaler then groups those enables into bit periods. For each bit period it issues one bit tick and one mid-bit sample strobe. All outputs are single-cycle enables in the reference clock domain, so the block creates no derived clock.

Software sets up the block through a small word-addressed register port. The write takes effect in one cycle, and the read is combinational. There are three registers: the oversampling ratio, the multiplier and the divider. Any write to any of them restarts both the accumulator and the prescaler. The new rate therefore always begins from a known phase.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, the oversampling register reads 16, the multiplier reads 0 and the divider reads 0, and `fuart_en` stays low.
- R2: The registers sit at these byte offsets: oversampling ratio at 0x0, multiplier at 0x4, divider at 0x8. The oversampling ratio keeps the low 8 bits of `wdata`, and the multiplier and divider keep all 24 bits. On a read, any bits not stored return zero. Any other address reads as zero.
- R3: When 0 < MUL < DIV, the number of `fuart_en` pulses in the N cycles after a write is within one of N × MUL / DIV.
- R4: When MUL ≥ DIV and both are nonzero, `fuart_en` is high in every cycle, starting with the second cycle after the write.
- R5: When MUL or DIV is zero, `fuart_en`, `bit_tick` and `sample_stb` all stay low.
- R6: `bit_tick` pulses for one cycle once every PS `fuart_en` pulses, on the pulse whose 0-based index within the bit is PS−1.
- R7: `sample_stb` pulses on the pulse whose 0-based index within the bit is floor(PS/2). With one pulse per cycle, it therefore comes floor(PS/2)+1 cycles after a bit tick.
- R8: An oversampling value of 0 behaves exactly like 1, so a bit tick comes on every `fuart_en` pulse.
- R9: A register write clears the accumulator and the prescaler. For MUL=1 and DIV=4, the first `fuart_en` is seen 4 cycles after the write. With saturated pulses and PS=P, the first `bit_tick` is seen P+1 cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| addr | input | 4 | Register byte offset |
| wdata | input | 24 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| fuart_en | output | 1 | Fractional-rate clock enable |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit period |
| sample_stb | output | 1 | One-cycle mid-bit sample strobe |

## Verification
The rate is tried with several ratios:
- 3/7 and 1/4 are small ratios; 1/4 divides evenly.
- 5000/9973 and 123457/1000003 are large coprime ratios, which bring out accumulator width and remainder errors.
- Ratios with MUL ≥ DIV test saturation.
- Zero operands test that the block stays silent.

Tick and strobe spacing is measured for PS values 1, 2, 3, 16 and 37, and for 0. Odd, even and degenerate values separate a wrong terminal count from a wrong midpoint. Cases where the strobe and the tick coincide are included. A fractional 1/3 rate with PS=4 shows that the prescaler counts enables and not clock cycles. Restart tests rewrite a register in mid-phase and check the exact position of the first enable and of the first tick.

// File: rtl/frac_baud_pkg.sv
// Package: shared register offsets and decode for the fractional UART clock generator.
// Assumes byte offsets fit in any address width of at least 4 bits.
package frac_baud_pkg;

    localparam int unsigned OFS_OSR = 32'h0;
    localparam int unsigned OFS_MUL = 32'h4;
    localparam int unsigned OFS_DIV = 32'h8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_OSR,
        SEL_MUL,
        SEL_DIV
    } reg_sel_e;

    // Map a byte offset onto the register it selects.
    function automatic reg_sel_e decode_addr(input int unsigned a);
        case (a)
            OFS_OSR: decode_addr = SEL_OSR;
            OFS_MUL: decode_addr = SEL_MUL;
            OFS_DIV: decode_addr = SEL_DIV;
            default: decode_addr = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/frac_baud_regs.sv
// Register file: holds the oversampling ratio, multiplier and divider.
// The write port is single-cycle and the read is combinational.
// Any register write raises restart_o for that cycle.
// Assumes PSW <= RW < DW.
module frac_baud_regs
    import frac_baud_pkg::*;
#(
    parameter int AW      = 4,
    parameter int RW      = 24,
    parameter int PSW     = 8,
    parameter int DW      = 32,
    parameter int PS_INIT = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [RW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic [PSW-1:0] ps_o,
    output logic [RW-1:0]  mul_o,
    output logic [RW-1:0]  div_o,
    output logic           restart_o
);

    localparam int PS_PAD = DW - PSW;
    localparam int RW_PAD = DW - RW;

    reg_sel_e sel;
    logic [PSW-1:0] ps_q;
    logic [RW-1:0]  mul_q;
    logic [RW-1:0]  div_q;

    // Decode the offset once for both the read and the write path.
    assign sel = decode_addr(32'(addr));

    // Capture write data into the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q  <= PSW'(PS_INIT);
            mul_q <= '0;
            div_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_OSR: ps_q  <= wdata[PSW-1:0];
                SEL_MUL: mul_q <= wdata;
                SEL_DIV: div_q <= wdata;
                default: ;
            endcase
        end
    end

    // Zero-extend the selected register onto the read bus.
    always_comb begin
        case (sel)
            SEL_OSR: rdata = {{PS_PAD{1'b0}}, ps_q};
            SEL_MUL: rdata = {{RW_PAD{1'b0}}, mul_q};
            SEL_DIV: rdata = {{RW_PAD{1'b0}}, div_q};
            default: rdata = '0;
        endcase
    end

    // Flag that the rate setting has changed.
    assign restart_o = wr_en && (sel != SEL_NONE);

    assign ps_o  = ps_q;
    assign mul_o = mul_q;
    assign div_o = div_q;

    AST_MUL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_MUL) |=> (mul_o == $past(wdata))); // R2
    AST_OSR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_OSR) |=> (ps_o == $past(wdata[PSW-1:0]))); // R2

endmodule

// File: rtl/frac_baud_accum.sv
// Phase accumulator: adds MUL every reference cycle. Each time the sum
// reaches DIV, it removes DIV and registers one enable pulse.
// It saturates at one pulse per cycle when MUL >= DIV, and stays idle when
// either operand is zero. Assumes the operands change only together with
// clear_i, so the accumulator always stays below DIV.
module frac_baud_accum #(
    parameter int RW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [RW-1:0] mul_i,
    input  logic [RW-1:0] div_i,
    output logic          fire_o
);

    logic [RW-1:0] acc_q;
    logic [RW:0]   sum;
    logic [RW-1:0] wrapped;
    logic          idle;
    logic          saturate;

    // Form the next phase, one bit wider so the carry is kept.
    assign sum      = {1'b0, acc_q} + {1'b0, mul_i};
    assign wrapped  = RW'(sum - {1'b0, div_i});
    assign idle     = (mul_i == '0) || (div_i == '0);
    assign saturate = (mul_i >= div_i);

    // Advance the phase and register the enable for this step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || idle) begin
            acc_q  <= '0;
            fire_o <= 1'b0;
        end else if (saturate) begin
            acc_q  <= '0;
            fire_o <= 1'b1;
        end else if (sum >= {1'b0, div_i}) begin
            acc_q  <= wrapped;
            fire_o <= 1'b1;
        end else begin
            acc_q  <= sum[RW-1:0];
            fire_o <= 1'b0;
        end
    end

    AST_PHASE_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i != '0) |-> (acc_q < div_i)); // R3
    AST_SAT_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !idle && saturate) |=> fire_o); // R4
    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> !fire_o); // R5

endmodule

// File: rtl/frac_baud_presc.sv
// Prescaler: counts the enable pulses inside one bit period.
// It registers a bit tick on pulse index PS-1 and a sample strobe on pulse
// index floor(PS/2). A ratio of zero is treated as one.
// Assumes ps_i changes only together with clear_i.
module frac_baud_presc #(
    parameter int PSW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           pulse_i,
    input  logic [PSW-1:0] ps_i,
    output logic           tick_o,
    output logic           stb_o
);

    logic [PSW-1:0] ps_eff;
    logic [PSW-1:0] last_idx;
    logic [PSW-1:0] mid_idx;
    logic [PSW-1:0] cnt_q;

    // Derive the effective ratio and the two decode points.
    assign ps_eff   = (ps_i == '0) ? PSW'(1) : ps_i;
    assign last_idx = ps_eff - PSW'(1);
    assign mid_idx  = ps_eff >> 1;

    // Count pulses and register the tick and the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
            stb_o  <= 1'b0;
        end else if (pulse_i) begin
            tick_o <= (cnt_q == last_idx);
            stb_o  <= (cnt_q == mid_idx);
            cnt_q  <= (cnt_q == last_idx) ? '0 : cnt_q + PSW'(1);
        end else begin
            tick_o <= 1'b0;
            stb_o  <= 1'b0;
        end
    end

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ps_eff); // R6
    AST_TICK_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(pulse_i)); // R6
    AST_STB_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> $past(pulse_i)); // R7
    AST_PS_ZERO_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_i == '0 && pulse_i && !clear_i) |=> (tick_o && stb_o)); // R8

endmodule

// File: rtl/frac_baud_gen.sv
// Top: fractional UART clock generator. It joins the register file, the
// phase accumulator and the prescaler. A register write restarts both
// counters in the same cycle. Every output is a clock enable in the
// reference clock domain.
module frac_baud_gen #(
    parameter int AW      = 4,
    parameter int RW      = 24,
    parameter int PSW     = 8,
    parameter int DW      = 32,
    parameter int PS_INIT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [RW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          fuart_en,
    output logic          bit_tick,
    output logic          sample_stb
);

    logic [PSW-1:0] ps;
    logic [RW-1:0]  mul;
    logic [RW-1:0]  div;
    logic           restart;

    // Configuration registers.
    frac_baud_regs #(
        .AW(AW), .RW(RW), .PSW(PSW), .DW(DW), .PS_INIT(PS_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ps_o(ps), .mul_o(mul), .div_o(div), .restart_o(restart)
    );

    // Fractional-rate enable.
    frac_baud_accum #(.RW(RW)) u_accum (
        .clk(clk), .rst_n(rst_n), .clear_i(restart),
        .mul_i(mul), .div_i(div), .fire_o(fuart_en)
    );

    // Bit period and mid-bit strobe.
    frac_baud_presc #(.PSW(PSW)) u_presc (
        .clk(clk), .rst_n(rst_n), .clear_i(restart), .pulse_i(fuart_en),
        .ps_i(ps), .tick_o(bit_tick), .stb_o(sample_stb)
    );

    AST_NO_TICK_WITHOUT_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mul == '0 || div == '0) |=> ##1 !bit_tick); // R5

endmodule

// File: tb/sim_frac_baud_gen.sv
// Directed bench for frac_baud_gen. Each task checks one scenario.
module sim_frac_baud_gen;

    localparam int AW  = 4;
    localparam int RW  = 24;
    localparam int PSW = 8;
    localparam int DW  = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [RW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          fuart_en, bit_tick, sample_stb;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    frac_baud_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .fuart_en(fuart_en), .bit_tick(bit_tick), .sample_stb(sample_stb)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Write one register. Returns at the falling edge just after the write edge.
    task automatic wr(input int a, input longint d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = AW'(a);
        wdata = RW'(d);
        @(negedge clk);
        wr_en = 1'b0;
        addr  = '0;
    endtask

    task automatic rd(input int a, output longint d);
        addr = AW'(a);
        #1;
        d = longint'(rdata);
        addr = '0;
    endtask

    task automatic count(input int n, output int f, output int t, output int s);
        f = 0; t = 0; s = 0;
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            f += int'(fuart_en);
            t += int'(bit_tick);
            s += int'(sample_stb);
        end
    endtask

    task automatic t_reset();
        longint v;
        int f, t, s;
        rd(0, v); check(v == 16, "R1", "oversampling reset", v, 16);
        rd(4, v); check(v == 0,  "R1", "multiplier reset", v, 0);
        rd(8, v); check(v == 0,  "R1", "divider reset", v, 0);
        count(50, f, t, s);
        check(f == 0, "R1", "enables after reset", f, 0);
    endtask

    task automatic t_regs();
        longint v;
        wr(0, 24'hFFFFFF); rd(0, v); check(v == 255,      "R2", "oversampling width", v, 255);
        wr(4, 24'hFFFFFF); rd(4, v); check(v == 24'hFFFFFF, "R2", "multiplier width", v, 24'hFFFFFF);
        wr(8, 24'h123456); rd(8, v); check(v == 24'h123456, "R2", "divider readback", v, 24'h123456);
        rd(12, v); check(v == 0, "R2", "unmapped 0xC", v, 0);
        rd(2, v);  check(v == 0, "R2", "unmapped 0x2", v, 0);
        wr(0, 16);
    endtask

    task automatic t_rate(input longint m, input longint d);
        int f, t, s;
        longint exp;
        wr(8, d);
        wr(4, m);
        count(5000, f, t, s);
        exp = (5000 * m) / d;
        check((f - exp <= 1) && (exp - f <= 1), "R3", $sformatf("rate %0d/%0d", m, d), f, exp);
    endtask

    task automatic t_sat(input longint m, input longint d);
        int f, t, s;
        wr(8, d);
        wr(4, m);
        @(negedge clk);
        count(100, f, t, s);
        check(f == 100, "R4", $sformatf("saturated %0d/%0d", m, d), f, 100);
    endtask

    task automatic t_zero(input longint m, input longint d);
        int f, t, s;
        wr(8, d);
        wr(4, m);
        count(200, f, t, s);
        check(f == 0, "R5", $sformatf("enables with %0d/%0d", m, d), f, 0);
        check(t == 0 && s == 0, "R5", "ticks and strobes while idle", t + s, 0);
    endtask

    // Measure the spacing from the second to the third tick, and from the
    // second tick to the next strobe.
    task automatic t_tick(input string req, input int p, input longint m, input longint d,
                          input int exp_gap, input int exp_stb);
        int j = 0, nt = 0, t2 = 0, t3 = 0, s = 0;
        wr(4, m);
        wr(8, d);
        wr(0, p);
        while (!(nt >= 3 && s != 0) && j < 3000) begin
            @(negedge clk);
            j++;
            if (bit_tick) begin
                nt++;
                if (nt == 2) t2 = j;
                if (nt == 3) t3 = j;
            end
            if (sample_stb && nt >= 2 && j > t2 && s == 0) s = j;
        end
        check(t3 - t2 == exp_gap, req, $sformatf("tick gap PS=%0d", p), t3 - t2, exp_gap);
        check(s - t2 == exp_stb, "R7", $sformatf("strobe offset PS=%0d", p), s - t2, exp_stb);
    endtask

    task automatic t_restart();
        int first = 0;
        wr(0, 16);
        wr(8, 4);
        wr(4, 1);
        repeat (6) @(negedge clk);
        wr(4, 1);
        for (int j = 1; j <= 8; j++) begin
            @(negedge clk);
            if (fuart_en && first == 0) first = j;
        end
        check(first == 4, "R9", "first enable after rewrite", first, 4);
        first = 0;
        wr(4, 1);
        wr(8, 1);
        wr(0, 5);
        repeat (3) @(negedge clk);
        wr(0, 5);
        for (int j = 1; j <= 12; j++) begin
            @(negedge clk);
            if (bit_tick && first == 0) first = j;
        end
        check(first == 6, "R9", "first tick after rewrite", first, 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wr_en = 1'b0;
        addr  = '0;
        wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_rate(3, 7);
        t_rate(1, 4);
        t_rate(5000, 9973);
        t_rate(123457, 1000003);
        t_sat(5, 5);
        t_sat(9, 3);
        t_zero(0, 7);
        t_zero(7, 0);
        t_tick("R6", 1, 1, 1, 1, 1);
        t_tick("R6", 2, 1, 1, 2, 2);
        t_tick("R6", 3, 1, 1, 3, 2);
        t_tick("R6", 16, 1, 1, 16, 9);
        t_tick("R6", 37, 1, 1, 37, 19);
        t_tick("R6", 4, 1, 3, 12, 9);
        t_tick("R8", 0, 1, 1, 1, 1);
        t_restart();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule